// File: doc/BRIEF.md
# Output Modulation and Trap Stage

This block is the last stage in front of the pins of a three-phase PWM unit. It takes the compare states of a main timer (one per phase) and one compare state of an auxiliary timer. From these it drives six phase outputs and one auxiliary output. Each phase produces a pair of outputs: a direct output at even bit 2x and a complementary output at odd bit 2x+1. The six bits run, from bit 5 down to bit 0: phase-2 complementary, phase-2 direct, phase-1 complementary, phase-1 direct, phase-0 complementary, phase-0 direct.

Each output can be gated by the main compare signals, by the auxiliary compare signal (optionally inverted), and by a six-bit multi-channel pattern. An output that is not active drives its own programmable passive level. An active output drives the complement of that level.

The multi-channel pattern and two three-bit Hall registers (expected and current) are loaded from shadow copies. The pattern transfer is requested first and then completed on a synchronization strobe. A reminder flag shows that a transfer is still pending. The Hall transfer is immediate.

A trap state forces the outputs selected by their trap enables to their passive level. The trap is raised either by software strobes or by an active-low pin that passes through a synchronizer. Once the trap condition is gone, the trap state ends on a match of the main timer, on a match of the auxiliary timer, or immediately.

Top module: `mod_trap_stage`

## Requirements
- R1: After reset, mcPattern, hallExp, hallCur, reminder, trapFlag and trapActive are all zero.
- R2: Main modulation works per output. The main signal for output bit 2x is mainCmp[x] and for bit 2x+1 it is ~mainCmp[x]. An output is active only when at least one of its enable bits (mainModEn[i] or auxModEn[i]) is set and every enabled source is 1. The output level is the active state XOR passiveLvl[i], so an output with no enables drives its passive level.
- R3: Auxiliary modulation uses auxCmp XOR auxInvert as the source signal for every output whose auxModEn bit is set.
- R4: When mcmEn=1, output i can be active only if mcPattern[i]=1. When mcmEn=0, the pattern has no effect on the outputs.
- R5: A pulse on shadowWr stores shadowPat, shadowExp and shadowCur in the shadow registers. It does not change mcPattern, hallExp or hallCur.
- R6: A pulse on patXferReq sets reminder at the next edge. On an edge where syncStrobe=1 and either reminder=1 or patXferReq=1, mcPattern takes the shadow pattern and reminder clears. A syncStrobe with nothing pending changes nothing.
- R7: A pulse on hallXferReq copies both Hall shadows into hallExp and hallCur at the next edge.
- R8: passiveLvl[5:0] sets the passive level of each phase output and passiveLvl[6] sets that of outAux.
- R9: outAux is active when auxOutEn=1 and auxCmp=1 (auxInvert does not apply to outAux). Otherwise outAux drives passiveLvl[6].
- R10: While trapActive=1, each output whose trapEnMain bit is set, and outAux if trapEnAux=1, drives its passive level. Outputs without a trap enable keep their normal value.
- R11: When swTrapMode=0, trapPinN low raises trapFlag and trapActive on the (SYNC_STAGES+1)-th edge after the pin falls. When swTrapMode=1, swTrapSet raises the flag at the next edge, swTrapClr clears it at the next edge, and the pin is ignored. trapFlag=1 always implies trapActive=1.
- R12: trapActive stays set while trapFlag is set. After trapFlag is clear, trapActive clears on an edge with mainMatch when trapRelSel=2'b00, with auxMatch when trapRelSel=2'b01, and at the same edge the flag clears when trapRelSel[1]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mainCmp | input | 3 | Main timer compare state per phase |
| auxCmp | input | 1 | Auxiliary timer compare state |
| auxInvert | input | 1 | Inverts auxCmp for modulation |
| mainModEn | input | 6 | Per-output main modulation enable |
| auxModEn | input | 6 | Per-output auxiliary modulation enable |
| mcmEn | input | 1 | Multi-channel pattern gating enable |
| auxOutEn | input | 1 | Auxiliary output follows auxCmp |
| passiveLvl | input | 7 | Passive level per pin, bit 6 for outAux |
| trapEnMain | input | 6 | Per-output trap enable |
| trapEnAux | input | 1 | Trap enable for outAux |
| swTrapMode | input | 1 | 1: software trap source, 0: pin source |
| swTrapSet | input | 1 | Software trap set strobe |
| swTrapClr | input | 1 | Software trap clear strobe |
| trapPinN | input | 1 | Active-low trap pin |
| trapRelSel | input | 2 | Trap release event select |
| mainMatch | input | 1 | Main timer match strobe |
| auxMatch | input | 1 | Auxiliary timer match strobe |
| shadowWr | input | 1 | Shadow register write strobe |
| shadowPat | input | 6 | Shadow pattern data |
| shadowExp | input | 3 | Shadow expected Hall data |
| shadowCur | input | 3 | Shadow current Hall data |
| patXferReq | input | 1 | Pattern transfer request |
| hallXferReq | input | 1 | Hall transfer request |
| syncStrobe | input | 1 | Pattern transfer synchronization strobe |
| outMain | output | 6 | Phase outputs |
| outAux | output | 1 | Auxiliary output |
| mcPattern | output | 6 | Active multi-channel pattern |
| reminder | output | 1 | Pattern transfer pending |
| hallExp | output | 3 | Active expected Hall pattern |
| hallCur | output | 3 | Active current Hall pattern |
| trapFlag | output | 1 | Trap condition present |
| trapActive | output | 1 | Trap forcing in effect |

## Verification
The hardest situation to reach from the ports is a trap whose condition has already gone while the forcing must persist. Only a match of the correct timer may end it, and a match of the other timer must not. The bench raises the trap, removes the condition, and then observes trapActive and the forced pins across a pulse of the wrong match strobe before it sends the right one. It does this once for the software source and once for the pin source, with the synchronizer latency counted edge by edge. It also drives a synchronization strobe with nothing pending, and shadow writes without a transfer, to show that the active registers stay unchanged.

// File: rtl/mod_trap_pkg.sv
package mod_trap_pkg;
  typedef struct packed {
    logic wrShadow;
    logic loadPat;
    logic loadHall;
    logic trapForce;
  } stageStrobes_t;
endpackage

// File: rtl/mod_trap_sync.sv
module mod_trap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) q <= '1;
        else       q <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) q <= '1;
        else       q <= {q[STAGES-2:0], din};
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/mod_trap_ctrl.sv
module mod_trap_ctrl
  import mod_trap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          swTrapMode,
  input  logic          swTrapSet,
  input  logic          swTrapClr,
  input  logic          trapPinN,
  input  logic [1:0]    trapRelSel,
  input  logic          mainMatch,
  input  logic          auxMatch,
  input  logic          shadowWr,
  input  logic          patXferReq,
  input  logic          hallXferReq,
  input  logic          syncStrobe,
  output stageStrobes_t strb,
  output logic          reminder,
  output logic          trapFlag,
  output logic          trapActive
);
  logic pinSyncN;
  logic relEvt, flagNext, activeNext, loadPat;

  mod_trap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (trapPinN),
    .dout(pinSyncN)
  );

  always_comb begin
    relEvt     = trapRelSel[1] | (trapRelSel[0] ? auxMatch : mainMatch);
    flagNext   = swTrapMode ? ((trapFlag | swTrapSet) & ~swTrapClr) : ~pinSyncN;
    activeNext = flagNext | (trapActive & ~relEvt);
    loadPat    = syncStrobe & (reminder | patXferReq);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reminder   <= 1'b0;
      trapFlag   <= 1'b0;
      trapActive <= 1'b0;
    end else begin
      trapFlag   <= flagNext;
      trapActive <= activeNext;
      if (loadPat)         reminder <= 1'b0;
      else if (patXferReq) reminder <= 1'b1;
    end
  end

  always_comb begin
    strb.wrShadow  = shadowWr;
    strb.loadPat   = loadPat;
    strb.loadHall  = hallXferReq;
    strb.trapForce = trapActive;
  end

  // R6
  reminder_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    patXferReq && !syncStrobe |=> reminder);
  // R6
  reminder_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    reminder && syncStrobe |=> !reminder);
  // R11
  flag_implies_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapFlag |-> trapActive);
  // R12
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapActive && !relEvt |=> trapActive);
endmodule

// File: rtl/mod_trap_datapath.sv
module mod_trap_datapath
  import mod_trap_pkg::*;
#(
  parameter int NUM_PHASES = 3,
  parameter int HALL_W     = 3,
  localparam int OUT_W     = 2 * NUM_PHASES,
  localparam int PSL_W     = OUT_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  stageStrobes_t       strb,
  input  logic [NUM_PHASES-1:0] mainCmp,
  input  logic                auxCmp,
  input  logic                auxInvert,
  input  logic [OUT_W-1:0]    mainModEn,
  input  logic [OUT_W-1:0]    auxModEn,
  input  logic                mcmEn,
  input  logic                auxOutEn,
  input  logic [PSL_W-1:0]    passiveLvl,
  input  logic [OUT_W-1:0]    trapEnMain,
  input  logic                trapEnAux,
  input  logic [OUT_W-1:0]    shadowPat,
  input  logic [HALL_W-1:0]   shadowExp,
  input  logic [HALL_W-1:0]   shadowCur,
  output logic [OUT_W-1:0]    outMain,
  output logic                outAux,
  output logic [OUT_W-1:0]    mcPattern,
  output logic [HALL_W-1:0]   hallExp,
  output logic [HALL_W-1:0]   hallCur
);
  logic [OUT_W-1:0]  shPat;
  logic [HALL_W-1:0] shExp, shCur;
  logic [OUT_W-1:0]  mainSig, outActive;
  logic              auxSig, auxActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPat     <= '0;
      shExp     <= '0;
      shCur     <= '0;
      mcPattern <= '0;
      hallExp   <= '0;
      hallCur   <= '0;
    end else begin
      if (strb.wrShadow) begin
        shPat <= shadowPat;
        shExp <= shadowExp;
        shCur <= shadowCur;
      end
      if (strb.loadPat) mcPattern <= shPat;
      if (strb.loadHall) begin
        hallExp <= shExp;
        hallCur <= shCur;
      end
    end
  end

  assign auxSig = auxCmp ^ auxInvert;

  generate
    for (genvar ph = 0; ph < NUM_PHASES; ph++) begin : g_phase
      assign mainSig[2*ph]   = mainCmp[ph];
      assign mainSig[2*ph+1] = ~mainCmp[ph];
    end
    for (genvar i = 0; i < OUT_W; i++) begin : g_out
      logic anyEn, mainOk, auxOk, patOk, forced;
      always_comb begin
        anyEn        = mainModEn[i] | auxModEn[i];
        mainOk       = ~mainModEn[i] | mainSig[i];
        auxOk        = ~auxModEn[i] | auxSig;
        patOk        = ~mcmEn | mcPattern[i];
        outActive[i] = anyEn & mainOk & auxOk & patOk;
        forced       = strb.trapForce & trapEnMain[i];
        outMain[i]   = forced ? passiveLvl[i] : (outActive[i] ^ passiveLvl[i]);
      end
    end
  endgenerate

  always_comb begin
    auxActive = auxOutEn & auxCmp;
    outAux    = (strb.trapForce & trapEnAux) ? passiveLvl[OUT_W]
                                             : (auxActive ^ passiveLvl[OUT_W]);
  end

  // R10
  trap_passive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.trapForce |-> (((outMain ^ passiveLvl[OUT_W-1:0]) & trapEnMain) == '0));
  // R6
  pattern_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPat |=> mcPattern == $past(shPat));
  // R7
  hall_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadHall |=> (hallExp == $past(shExp)) && (hallCur == $past(shCur)));
  // R5
  shadow_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrShadow && !strb.loadPat |=> $stable(mcPattern));
endmodule

// File: rtl/mod_trap_stage.sv
module mod_trap_stage
  import mod_trap_pkg::*;
#(
  parameter int NUM_PHASES  = 3,
  parameter int HALL_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int OUT_W      = 2 * NUM_PHASES,
  localparam int PSL_W      = OUT_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PHASES-1:0] mainCmp,
  input  logic                  auxCmp,
  input  logic                  auxInvert,
  input  logic [OUT_W-1:0]      mainModEn,
  input  logic [OUT_W-1:0]      auxModEn,
  input  logic                  mcmEn,
  input  logic                  auxOutEn,
  input  logic [PSL_W-1:0]      passiveLvl,
  input  logic [OUT_W-1:0]      trapEnMain,
  input  logic                  trapEnAux,
  input  logic                  swTrapMode,
  input  logic                  swTrapSet,
  input  logic                  swTrapClr,
  input  logic                  trapPinN,
  input  logic [1:0]            trapRelSel,
  input  logic                  mainMatch,
  input  logic                  auxMatch,
  input  logic                  shadowWr,
  input  logic [OUT_W-1:0]      shadowPat,
  input  logic [HALL_W-1:0]     shadowExp,
  input  logic [HALL_W-1:0]     shadowCur,
  input  logic                  patXferReq,
  input  logic                  hallXferReq,
  input  logic                  syncStrobe,
  output logic [OUT_W-1:0]      outMain,
  output logic                  outAux,
  output logic [OUT_W-1:0]      mcPattern,
  output logic                  reminder,
  output logic [HALL_W-1:0]     hallExp,
  output logic [HALL_W-1:0]     hallCur,
  output logic                  trapFlag,
  output logic                  trapActive
);
  stageStrobes_t strb;

  mod_trap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .swTrapMode (swTrapMode),
    .swTrapSet  (swTrapSet),
    .swTrapClr  (swTrapClr),
    .trapPinN   (trapPinN),
    .trapRelSel (trapRelSel),
    .mainMatch  (mainMatch),
    .auxMatch   (auxMatch),
    .shadowWr   (shadowWr),
    .patXferReq (patXferReq),
    .hallXferReq(hallXferReq),
    .syncStrobe (syncStrobe),
    .strb       (strb),
    .reminder   (reminder),
    .trapFlag   (trapFlag),
    .trapActive (trapActive)
  );

  mod_trap_datapath #(.NUM_PHASES(NUM_PHASES), .HALL_W(HALL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .mainCmp   (mainCmp),
    .auxCmp    (auxCmp),
    .auxInvert (auxInvert),
    .mainModEn (mainModEn),
    .auxModEn  (auxModEn),
    .mcmEn     (mcmEn),
    .auxOutEn  (auxOutEn),
    .passiveLvl(passiveLvl),
    .trapEnMain(trapEnMain),
    .trapEnAux (trapEnAux),
    .shadowPat (shadowPat),
    .shadowExp (shadowExp),
    .shadowCur (shadowCur),
    .outMain   (outMain),
    .outAux    (outAux),
    .mcPattern (mcPattern),
    .hallExp   (hallExp),
    .hallCur   (hallCur)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (mcPattern == '0) && !reminder && !trapActive);
endmodule

// File: tb/mod_trap_stage_bench.sv
module mod_trap_stage_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] mainCmp = '0;
  logic auxCmp = 0, auxInvert = 0, mcmEn = 0, auxOutEn = 0;
  logic [5:0] mainModEn = '0, auxModEn = '0, trapEnMain = '0, shadowPat = '0;
  logic [6:0] passiveLvl = '0;
  logic trapEnAux = 0, swTrapMode = 1, swTrapSet = 0, swTrapClr = 0, trapPinN = 1;
  logic [1:0] trapRelSel = '0;
  logic mainMatch = 0, auxMatch = 0, shadowWr = 0, patXferReq = 0, hallXferReq = 0, syncStrobe = 0;
  logic [2:0] shadowExp = '0, shadowCur = '0;
  logic [5:0] outMain, mcPattern;
  logic outAux, reminder, trapFlag, trapActive;
  logic [2:0] hallExp, hallCur;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod_trap_stage u_mod_trap_stage (
    .clk(clk), .rstN(rstN), .mainCmp(mainCmp), .auxCmp(auxCmp), .auxInvert(auxInvert),
    .mainModEn(mainModEn), .auxModEn(auxModEn), .mcmEn(mcmEn), .auxOutEn(auxOutEn),
    .passiveLvl(passiveLvl), .trapEnMain(trapEnMain), .trapEnAux(trapEnAux),
    .swTrapMode(swTrapMode), .swTrapSet(swTrapSet), .swTrapClr(swTrapClr),
    .trapPinN(trapPinN), .trapRelSel(trapRelSel), .mainMatch(mainMatch), .auxMatch(auxMatch),
    .shadowWr(shadowWr), .shadowPat(shadowPat), .shadowExp(shadowExp), .shadowCur(shadowCur),
    .patXferReq(patXferReq), .hallXferReq(hallXferReq), .syncStrobe(syncStrobe),
    .outMain(outMain), .outAux(outAux), .mcPattern(mcPattern), .reminder(reminder),
    .hallExp(hallExp), .hallCur(hallCur), .trapFlag(trapFlag), .trapActive(trapActive)
  );

  // {mainCmp, auxCmp, auxInvert, mainModEn, auxModEn, passiveLvl, expMain, expAux}
  localparam logic [30:0] VECS [0:7] = '{
    {3'b000, 1'b0, 1'b0, 6'h3F, 6'h00, 7'h00, 6'h2A, 1'b0},
    {3'b111, 1'b0, 1'b0, 6'h3F, 6'h00, 7'h00, 6'h15, 1'b0},
    {3'b101, 1'b0, 1'b0, 6'h3F, 6'h00, 7'h3F, 6'h26, 1'b0},
    {3'b000, 1'b1, 1'b0, 6'h00, 6'h3F, 7'h00, 6'h3F, 1'b0},
    {3'b000, 1'b1, 1'b1, 6'h00, 6'h3F, 7'h40, 6'h00, 1'b1},
    {3'b111, 1'b1, 1'b0, 6'h3F, 6'h0F, 7'h00, 6'h15, 1'b0},
    {3'b111, 1'b0, 1'b0, 6'h0F, 6'h30, 7'h00, 6'h05, 1'b0},
    {3'b010, 1'b0, 1'b1, 6'h03, 6'h0C, 7'h7F, 6'h31, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pattern", mcPattern, 0);
    check("R1 hall", {hallExp, hallCur}, 0);
    check("R1 status", {reminder, trapFlag, trapActive}, 0);

    // R2 R3 R8 vector walk
    for (int v = 0; v < 8; v++) begin
      {mainCmp, auxCmp, auxInvert, mainModEn, auxModEn, passiveLvl} = VECS[v][30:7];
      #1;
      check("R2 R3 R8 outMain", outMain, VECS[v][6:1]);
      check("R8 outAux passive", outAux, VECS[v][0]);
      @(negedge clk);
    end

    // R5 shadow write leaves active registers alone
    shadowPat = 6'h2D; shadowExp = 3'b101; shadowCur = 3'b011; shadowWr = 1;
    tick(); shadowWr = 0;
    check("R5 pattern untouched", mcPattern, 0);
    check("R5 hall untouched", {hallExp, hallCur}, 0);

    // R7 hall transfer
    hallXferReq = 1; tick(); hallXferReq = 0;
    check("R7 hallExp", hallExp, 3'b101);
    check("R7 hallCur", hallCur, 3'b011);

    // R6 sync without pending request
    syncStrobe = 1; tick(); syncStrobe = 0;
    check("R6 idle sync pattern", mcPattern, 0);
    check("R6 idle sync reminder", reminder, 0);
    patXferReq = 1; tick(); patXferReq = 0;
    check("R6 reminder set", reminder, 1);
    check("R6 pattern waits", mcPattern, 0);
    tick();
    check("R6 still pending", reminder, 1);
    syncStrobe = 1; tick(); syncStrobe = 0;
    check("R6 pattern loaded", mcPattern, 6'h2D);
    check("R6 reminder cleared", reminder, 0);

    // R4 multi-channel gating
    mainCmp = 3'b000; auxCmp = 0; auxInvert = 0; mainModEn = 6'h3F; auxModEn = 0;
    passiveLvl = 0; mcmEn = 1; #1;
    check("R4 gated", outMain, 6'h28);
    mcmEn = 0; #1;
    check("R4 ungated", outMain, 6'h2A);

    // R9 aux output
    auxOutEn = 1; auxCmp = 1; auxInvert = 1; #1;
    check("R9 aux active", outAux, 1);
    auxCmp = 0; #1;
    check("R9 aux idle", outAux, 0);
    auxCmp = 1;

    // R11 pin ignored in software mode
    swTrapMode = 1; trapEnMain = 6'h0F; trapEnAux = 1; trapRelSel = 2'b00;
    trapPinN = 0; repeat (5) tick();
    check("R11 pin ignored", {trapFlag, trapActive}, 0);
    check("R11 out unforced", outMain, 6'h2A);
    trapPinN = 1;

    // R10 R11 software trap
    swTrapSet = 1; tick(); swTrapSet = 0;
    check("R11 sw set", {trapFlag, trapActive}, 2'b11);
    check("R10 forced outMain", outMain, 6'h20);
    check("R10 forced outAux", outAux, 0);
    mainMatch = 1; tick(); mainMatch = 0;
    check("R12 hold while flag", trapActive, 1);
    swTrapClr = 1; tick(); swTrapClr = 0;
    check("R11 sw clr", trapFlag, 0);
    check("R12 waits for match", trapActive, 1);
    auxMatch = 1; tick(); auxMatch = 0;
    check("R12 wrong match", trapActive, 1);
    mainMatch = 1; tick(); mainMatch = 0;
    check("R12 main release", trapActive, 0);
    check("R10 outputs restored", {outAux, outMain}, {1'b1, 6'h2A});

    // R11 R12 pin trap, auxiliary release
    swTrapMode = 0; trapRelSel = 2'b01;
    tick();
    trapPinN = 0;
    tick(); tick();
    check("R11 pin latency", trapActive, 0);
    tick();
    check("R11 pin trap", {trapFlag, trapActive}, 2'b11);
    trapPinN = 1;
    repeat (3) tick();
    check("R11 pin released flag", trapFlag, 0);
    check("R12 pin hold", trapActive, 1);
    mainMatch = 1; tick(); mainMatch = 0;
    check("R12 main ignored", trapActive, 1);
    auxMatch = 1; tick(); auxMatch = 0;
    check("R12 aux release", trapActive, 0);

    // R12 immediate release
    swTrapMode = 1; trapRelSel = 2'b10;
    swTrapSet = 1; tick(); swTrapSet = 0;
    check("R12 immediate set", trapActive, 1);
    swTrapClr = 1; tick(); swTrapClr = 0;
    check("R12 immediate release", {trapFlag, trapActive}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule